// File: doc/BRIEF.md
# Scalar Floating-Point Compare-to-Flags Unit

This unit compares two IEEE-754 scalar operands and reports the outcome as three integer-style condition bits (zero, parity, carry) plus an invalid-operation indication. Each operand port is 64 bits wide. A precision select chooses between single format, which looks only at the low 32 bits of each operand, and double format, which uses all 64 bits. A mode select chooses ordered or unordered behaviour. The two modes always produce the same condition bits for the same operands. They differ only in which NaN inputs raise the invalid indication.

The unit accepts a compare through a valid/ready handshake and returns the result one cycle later, qualified by `out_valid`. While the consumer holds `out_ready` low, the result stays on the outputs and new requests are refused. Overflow, auxiliary-carry and sign flag outputs are part of the result and are always zero. Exception masking, trap delivery and the architectural flags register are left to the surrounding logic.

Top module: `fpcmp_flags_unit`

## Requirements
- R1: With `dbl_sel`=0 only bits 31:0 of each operand are examined. Bits 63:32 have no effect on any output.
- R2: With `dbl_sel`=1 all 64 bits are examined. A difference in bits 63:32 changes the outcome.
- R3: The condition code {`flag_zf`,`flag_pf`,`flag_cf`} is:
  - 3'b111 when either operand is a NaN;
  - 3'b100 when the operands are equal;
  - 3'b001 when `opa` < `opb`;
  - 3'b000 when `opa` > `opb`.
- R4: Positive zero and negative zero compare as equal (code 3'b100).
- R5: `flag_of`, `flag_af` and `flag_sf` read 0 for every result.
- R6: With `ordered_sel`=1, `flag_invalid` is 1 exactly when either operand is a NaN of any kind.
- R7: With `ordered_sel`=0, `flag_invalid` is 1 exactly when either operand is a signalling NaN.
  - A NaN has an all-ones exponent and a nonzero fraction.
  - It is signalling when the fraction MSB is 0, and quiet when that bit is 1.
- R8: For the same operands and precision, both modes give the same condition code.
- R9: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its result appears after that edge, with `out_valid`=1.
- R10: `in_ready` equals (not `out_valid`) or `out_ready`.
  - While `out_valid`=1 and `out_ready`=0, the outputs hold and no request is accepted.
  - `out_valid` drops one cycle after the result is taken, unless a new request was accepted in the same cycle.
- R11: While `rst_n` is low, `out_valid` and every flag output read 0.
- R12: Ordering follows the sign and then the magnitude. Among negative values, the larger magnitude is the smaller number, and infinities are the extreme values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| dbl_sel | input | 1 | 1 = double format, 0 = single format (low 32 bits) |
| ordered_sel | input | 1 | 1 = ordered mode, 0 = unordered mode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| flag_zf | output | 1 | Zero condition bit |
| flag_pf | output | 1 | Parity condition bit (unordered) |
| flag_cf | output | 1 | Carry condition bit (less than) |
| flag_of | output | 1 | Overflow flag, always 0 |
| flag_af | output | 1 | Auxiliary-carry flag, always 0 |
| flag_sf | output | 1 | Sign flag, always 0 |
| flag_invalid | output | 1 | Invalid-operation indication |

## Verification
The bench builds the unit with its default format parameters: 8/23 exponent and fraction bits for single and 11/52 for double. This puts both generate branches and both NaN classifiers under test in one run. Operands are drawn from weighted categories: random bits, signed zeros, infinities, quiet and signalling NaNs, small magnitudes, and copies of the other operand, possibly with the sign flipped. This makes equality, the zero-sign case, negative ordering and every invalid condition frequent in both formats. Each random pair is sent in both modes to compare the codes, and single-format pairs carry random upper halves to show those bits are ignored.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef struct packed {
    logic zf;
    logic pf;
    logic cf;
  } cmp_flags_t;

  // Unordered wins over any ordering; equality wins over less-than.
  function automatic cmp_flags_t encode_flags(input logic unord,
                                              input logic eq,
                                              input logic lt);
    cmp_flags_t f;
    if (unord)   f = '{zf: 1'b1, pf: 1'b1, cf: 1'b1};
    else if (eq) f = '{zf: 1'b1, pf: 1'b0, cf: 1'b0};
    else if (lt) f = '{zf: 1'b0, pf: 1'b0, cf: 1'b1};
    else         f = '{zf: 1'b0, pf: 1'b0, cf: 1'b0};
    return f;
  endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W-1:0] body,
  output logic                    is_nan,
  output logic                    is_snan
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;

  always_comb begin
    exp_f    = body[EXP_W+FRAC_W-1:FRAC_W];
    frac_f   = body[FRAC_W-1:0];
    exp_ones = &exp_f;
    is_nan   = exp_ones & (|frac_f);
    // Signalling: quiet bit clear, payload below it nonzero.
    is_snan  = exp_ones & ~frac_f[FRAC_W-1] & (|frac_f[FRAC_W-2:0]);
  end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt,
  output logic         eq
);

  logic         sa, sb, both_zero, mag_lt, mag_gt;
  logic [W-2:0] ma, mb;

  always_comb begin
    sa        = a[W-1];
    sb        = b[W-1];
    ma        = a[W-2:0];
    mb        = b[W-2:0];
    both_zero = (ma == '0) && (mb == '0);
    mag_lt    = ma < mb;
    mag_gt    = ma > mb;
    eq        = both_zero | (a == b);
    // Negative pair: magnitude order reversed.
    lt        = ~both_zero & ((sa & ~sb) | (~sa & ~sb & mag_lt) | (sa & sb & mag_gt));
  end

  always_comb begin
    a_r3_lt_eq_exclusive: assert (!(lt && eq));
  end

endmodule

// File: rtl/fpcmp_core.sv
module fpcmp_core
  import fpcmp_pkg::*;
#(
  parameter int SP_EXP_W  = 8,
  parameter int SP_FRAC_W = 23,
  parameter int DP_EXP_W  = 11,
  parameter int DP_FRAC_W = 52,
  localparam int OP_W     = 1 + DP_EXP_W + DP_FRAC_W
) (
  input  logic [OP_W-1:0] opa,
  input  logic [OP_W-1:0] opb,
  input  logic            dbl_sel,
  input  logic            ordered_sel,
  output cmp_flags_t      flags,
  output logic            invalid
);

  logic [1:0] nan_a, nan_b, snan_a, snan_b, lt_f, eq_f;
  logic       unord, any_snan;

  // Index 0: single format, index 1: double format.
  for (genvar f = 0; f < 2; f++) begin : g_fmt
    localparam int EW = (f == 0) ? SP_EXP_W : DP_EXP_W;
    localparam int FW = (f == 0) ? SP_FRAC_W : DP_FRAC_W;
    localparam int TW = 1 + EW + FW;

    fpcmp_classify #(.EXP_W(EW), .FRAC_W(FW)) u_cls_a (
      .body(opa[TW-2:0]), .is_nan(nan_a[f]), .is_snan(snan_a[f])
    );
    fpcmp_classify #(.EXP_W(EW), .FRAC_W(FW)) u_cls_b (
      .body(opb[TW-2:0]), .is_nan(nan_b[f]), .is_snan(snan_b[f])
    );
    fpcmp_order #(.W(TW)) u_ord (
      .a(opa[TW-1:0]), .b(opb[TW-1:0]), .lt(lt_f[f]), .eq(eq_f[f])
    );
  end

  always_comb begin
    unord    = nan_a[dbl_sel] | nan_b[dbl_sel];
    any_snan = snan_a[dbl_sel] | snan_b[dbl_sel];
    flags    = encode_flags(unord, eq_f[dbl_sel], lt_f[dbl_sel]);
    invalid  = ordered_sel ? unord : any_snan;
  end

  always_comb begin
    a_r7_invalid_needs_nan: assert (!invalid || flags.pf);
  end

endmodule

// File: rtl/fpcmp_flags_unit.sv
module fpcmp_flags_unit
  import fpcmp_pkg::*;
#(
  parameter int SP_EXP_W  = 8,
  parameter int SP_FRAC_W = 23,
  parameter int DP_EXP_W  = 11,
  parameter int DP_FRAC_W = 52,
  localparam int OP_W     = 1 + DP_EXP_W + DP_FRAC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] opa,
  input  logic [OP_W-1:0] opb,
  input  logic            dbl_sel,
  input  logic            ordered_sel,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            flag_zf,
  output logic            flag_pf,
  output logic            flag_cf,
  output logic            flag_of,
  output logic            flag_af,
  output logic            flag_sf,
  output logic            flag_invalid
);

  cmp_flags_t core_flags, flags_q;
  logic       core_inv, inv_q;
  logic       valid_q, valid_d, accept, load_en;

  fpcmp_core #(
    .SP_EXP_W(SP_EXP_W), .SP_FRAC_W(SP_FRAC_W),
    .DP_EXP_W(DP_EXP_W), .DP_FRAC_W(DP_FRAC_W)
  ) u_core (
    .opa(opa), .opb(opb), .dbl_sel(dbl_sel), .ordered_sel(ordered_sel),
    .flags(core_flags), .invalid(core_inv)
  );

  // Next-state logic.
  always_comb begin
    in_ready = ~valid_q | out_ready;
    accept   = in_valid & in_ready;
    load_en  = accept;
    valid_d  = accept | (valid_q & ~out_ready);
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      flags_q <= '0;
      inv_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (load_en) begin
        flags_q <= core_flags;
        inv_q   <= core_inv;
      end
    end
  end

  assign out_valid    = valid_q;
  assign flag_zf      = flags_q.zf;
  assign flag_pf      = flags_q.pf;
  assign flag_cf      = flags_q.cf;
  assign flag_invalid = inv_q;
  assign flag_of      = 1'b0;
  assign flag_af      = 1'b0;
  assign flag_sf      = 1'b0;

  a_r9_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r10_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable({flag_zf, flag_pf, flag_cf, flag_invalid})));

  a_r10_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((!flag_pf && !(flag_zf && flag_cf)) || (flag_zf && flag_cf)));

endmodule

// File: tb/fpcmp_flags_unit_tb_top.sv
module fpcmp_flags_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic [63:0] opa = '0, opb = '0;
  logic        dbl_sel = 1'b0, ordered_sel = 1'b0;
  logic        in_ready, out_valid;
  logic        flag_zf, flag_pf, flag_cf, flag_of, flag_af, flag_sf, flag_invalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fpcmp_flags_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opa(opa), .opb(opb), .dbl_sel(dbl_sel), .ordered_sel(ordered_sel),
    .out_valid(out_valid), .out_ready(out_ready),
    .flag_zf(flag_zf), .flag_pf(flag_pf), .flag_cf(flag_cf),
    .flag_of(flag_of), .flag_af(flag_af), .flag_sf(flag_sf),
    .flag_invalid(flag_invalid)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Returns {zf,pf,cf,invalid} from the requirements.
  function automatic logic [3:0] model(input logic [63:0] a, input logic [63:0] b,
                                       input logic dbl, input logic ordm);
    logic na, nb, sna, snb, sa, sb;
    logic [62:0] ma, mb;
    logic signed [64:0] va, vb;
    logic [2:0] code;
    if (dbl) begin
      na = (a[62:52] == 11'h7ff) && (a[51:0] != 0); sna = na && !a[51];
      nb = (b[62:52] == 11'h7ff) && (b[51:0] != 0); snb = nb && !b[51];
      sa = a[63]; sb = b[63]; ma = a[62:0]; mb = b[62:0];
    end else begin
      na = (a[30:23] == 8'hff) && (a[22:0] != 0); sna = na && !a[22];
      nb = (b[30:23] == 8'hff) && (b[22:0] != 0); snb = nb && !b[22];
      sa = a[31]; sb = b[31]; ma = {32'b0, a[30:0]}; mb = {32'b0, b[30:0]};
    end
    va = sa ? -$signed({2'b0, ma}) : $signed({2'b0, ma});
    vb = sb ? -$signed({2'b0, mb}) : $signed({2'b0, mb});
    if (na || nb)      code = 3'b111;
    else if (va == vb) code = 3'b100;
    else if (va < vb)  code = 3'b001;
    else               code = 3'b000;
    return {code, ordm ? (na || nb) : (sna || snb)};
  endfunction

  function automatic logic [63:0] gen(input logic dbl);
    logic [63:0] r = {$urandom, $urandom};
    int k = $urandom_range(0, 7);
    case (k)
      3: if (dbl) r[62:0] = '0; else r[30:0] = '0;
      4: if (dbl) begin r[62:52] = '1; r[51:0] = '0; end
         else     begin r[30:23] = '1; r[22:0] = '0; end
      5: if (dbl) begin r[62:52] = '1; r[51] = 1'b1; end
         else     begin r[30:23] = '1; r[22] = 1'b1; end
      6: if (dbl) begin r[62:52] = '1; r[51] = 1'b0; r[0] = 1'b1; end
         else     begin r[30:23] = '1; r[22] = 1'b0; r[0] = 1'b1; end
      7: if (dbl) r[62:58] = '0; else r[30:26] = '0;
      default: ;
    endcase
    return r;
  endfunction

  task automatic send(input logic [63:0] a, input logic [63:0] b,
                      input logic dbl, input logic ordm);
    @(negedge clk);
    opa = a; opb = b; dbl_sel = dbl; ordered_sel = ordm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(input logic [63:0] a, input logic [63:0] b,
                     input logic dbl, input logic ordm, input string tag);
    logic [3:0] e;
    e = model(a, b, dbl, ordm);
    send(a, b, dbl, ordm);
    chk("R9 out_valid", {63'b0, out_valid}, 64'd1);
    chk({tag, " code"}, {61'b0, flag_zf, flag_pf, flag_cf}, {61'b0, e[3:1]});
    chk(ordm ? "R6 invalid" : "R7 invalid", {63'b0, flag_invalid}, {63'b0, e[0]});
    chk("R5 of/af/sf", {61'b0, flag_of, flag_af, flag_sf}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] c0;
    void'($urandom(32'd20240611));
    // R11: reset state
    repeat (2) @(negedge clk);
    chk("R11 reset out_valid", {63'b0, out_valid}, 64'd0);
    chk("R11 reset flags", {57'b0, flag_zf, flag_pf, flag_cf, flag_of, flag_af, flag_sf, flag_invalid}, 64'd0);
    rst_n = 1'b1;

    // Directed corners
    run(64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 1, 1, "R4 dbl zeros");
    run(64'h0000_0000_8000_0000, 64'h0000_0000_0000_0000, 0, 0, "R4 sgl zeros");
    run(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1, 1, "R3 1<2");
    run(64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 1, "R3 2>1");
    run(64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 0, "R3 equal");
    run(64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, 1, 1, "R12 -1>-2");
    run(64'hFFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 1, "R12 -inf<1");
    run(64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 1, "R6 qnan ordered");
    run(64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 0, "R7 qnan unordered");
    run(64'h0000_0000_7F80_0001, 64'h0000_0000_3F80_0000, 0, 0, "R7 snan unordered");
    run(64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_3F80_0000, 0, 1, "R1 upper ignored");
    chk("R1 equal despite upper", {61'b0, flag_zf, flag_pf, flag_cf}, 64'h4);
    run(64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_3F80_0000, 1, 1, "R2 upper used");
    chk("R2 not equal", {63'b0, flag_zf}, 64'd0);

    // R10: backpressure
    @(negedge clk);
    out_ready = 1'b0;
    opa = 64'h3FF0_0000_0000_0000; opb = 64'h3FF0_0000_0000_0000;
    dbl_sel = 1; ordered_sel = 1; in_valid = 1;
    @(negedge clk);
    chk("R10 stalled in_ready", {63'b0, in_ready}, 64'd0);
    chk("R10 first result", {61'b0, flag_zf, flag_pf, flag_cf}, 64'h4);
    opa = 64'h3FF0_0000_0000_0000; opb = 64'h4000_0000_0000_0000;
    @(negedge clk);
    chk("R10 hold valid", {63'b0, out_valid}, 64'd1);
    chk("R10 hold flags", {61'b0, flag_zf, flag_pf, flag_cf}, 64'h4);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 0;
    chk("R10 second valid", {63'b0, out_valid}, 64'd1);
    chk("R10 second flags", {61'b0, flag_zf, flag_pf, flag_cf}, 64'h1);
    @(negedge clk);
    chk("R10 valid drops", {63'b0, out_valid}, 64'd0);

    // R11: reset mid-run clears held result
    out_ready = 1'b0;
    send(64'h7FF8_0000_0000_0000, 64'h0, 1, 1);
    rst_n = 1'b0;
    #2;
    chk("R11 async clear", {56'b0, out_valid, flag_zf, flag_pf, flag_cf, flag_of, flag_af, flag_sf, flag_invalid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1; out_ready = 1'b1;

    // Random mix, each pair in both modes
    for (int i = 0; i < 500; i++) begin
      logic dbl, ordm;
      logic [63:0] a, b;
      int pick;
      dbl = 1'($urandom); ordm = 1'($urandom);
      a = gen(dbl);
      pick = $urandom_range(0, 3);
      if (pick == 0) b = a;
      else if (pick == 1) begin b = a; if (dbl) b[63] = ~b[63]; else b[31] = ~b[31]; end
      else b = gen(dbl);
      if (!dbl) begin a[63:32] = $urandom; b[63:32] = $urandom; end
      run(a, b, dbl, ordm, dbl ? "R12 random dbl" : "R1 random sgl");
      c0 = {flag_zf, flag_pf, flag_cf};
      run(a, b, dbl, !ordm, "R3 random other mode");
      chk("R8 modes agree", {61'b0, flag_zf, flag_pf, flag_cf}, {61'b0, c0});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule